// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer with Command Strobes

This block sits between an 8-bit processor whose low address byte and data byte share the same eight pins and the memories and peripherals on its board. On a clock edge where the address latch enable is high it captures the low address byte. It keeps that byte through the later data cycles and joins it with the dedicated high address byte into a stable 16-bit address.

During the data phase it turns the memory/IO select, read and write pins into four active-low command strobes. It also drives one of four memory chip selects from the upper address lines. It presents the write byte to the devices and returns the read byte to the shared pins.

A small phase machine orders the work. It has three states. PH_IDLE is entered on reset. PH_ADDR is held while the latch enable is high. PH_DATA follows once the latch enable has been low across a clock edge. The transitions are IDLE→ADDR on latch enable, ADDR→ADDR while it stays high, ADDR→DATA when it is low at an edge, and DATA→ADDR when it rises again. A parameter chooses between exhaustive and partial chip-select decoding.

Top module: `bdm_bus_demux`

## Requirements
- R1: After reset the captured low byte is 0, all four strobes and all four chip selects are high, the error flag is 0, and the read-data output enable is 0.
- R2: On each clock edge with the latch enable high, the low address pins are captured. The byte is held unchanged on edges where the latch enable is low. addr_o is {a_hi_i, captured byte}.
- R3: In the data phase, mem_rd_n_o is low for select 0 with read low, and mem_wr_n_o is low for select 0 with write low. io_rd_n_o is low for select 1 with read low, and io_wr_n_o is low for select 1 with write low. At most one strobe is low at a time.
- R4: Strobes and chip selects assert only in PH_DATA with the latch enable low. They never assert while the latch enable is high, nor in the cycle after the latch enable falls but before the next clock edge.
- R5: In the data phase, read and write both low is illegal. No strobe asserts and bus_err_o is 1. Outside that condition bus_err_o is 0.
- R6: For a memory access (select 0) in the data phase with address bit 13 high, chip select cs_n_o[k] goes low, where k = address bits 12..11. All other chip selects stay high. With bit 13 low, or for an IO access, none is low. Chip selects do not depend on the read and write pins.
- R7: With exhaustive decoding (EXHAUSTIVE=1), address bits 15..14 must also equal HI_MATCH (default 0) for any chip select to assert. Each device location therefore answers at exactly one address.
- R8: With partial decoding (EXHAUSTIVE=0), address bits 15..14 are ignored. The same device location appears at four aliased addresses.
- R9: dev_addr_o equals address bits 10..0.
- R10: While a read strobe is low, ad_oe_o is 1 and ad_o equals rdata_i. Otherwise ad_oe_o is 0 and ad_o is 0. While a write strobe is low, wdata_o equals ad_i. Otherwise wdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch enable, high during the address cycle |
| ad_i | input | 8 | Shared low address / data pins as seen by the block |
| a_hi_i | input | 8 | Dedicated high address byte |
| io_m_i | input | 1 | Access space: 0 memory, 1 IO |
| rd_n_i | input | 1 | Read request, active low |
| wr_n_i | input | 1 | Write request, active low |
| rdata_i | input | 8 | Read byte returned by the selected device |
| addr_o | output | 16 | Demultiplexed full address |
| dev_addr_o | output | 11 | Address bits routed to each memory device |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | IO read strobe, active low |
| io_wr_n_o | output | 1 | IO write strobe, active low |
| cs_n_o | output | 4 | Memory chip selects, active low |
| bus_err_o | output | 1 | Read and write requested together |
| wdata_o | output | 8 | Write byte presented to devices |
| ad_o | output | 8 | Read byte driven back onto the shared pins |
| ad_oe_o | output | 1 | Output enable for ad_o |

## Verification
Every value of the high address byte is swept under each of the four commands. This separates the select/read/write mapping and shows which high bits take part in decoding. Two instances sit side by side on the same stimulus, one exhaustive and one partial. Rows where bits 15..14 are nonzero therefore show that aliases appear only in partial mode.

The low byte is paired with a different data byte in every cycle, so a low byte that is not held would show up in addr_o. Conflicting read-plus-write cycles and a latch enable raised inside the data phase isolate the error path and the strobe qualification.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/bdm_phase_fsm.sv
module bdm_phase_fsm #(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale_i,
    input  logic [LO_W-1:0] ad_i,
    output logic [LO_W-1:0] lo_q_o,
    output logic            data_ph_o
);
    import bdm_pkg::*;

    phase_e          state_q;
    phase_e          state_d;
    logic [LO_W-1:0] lo_q;
    logic            armed_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (ale_i) state_d = PH_ADDR;
            PH_ADDR: if (!ale_i) state_d = PH_DATA;
            PH_DATA: if (ale_i) state_d = PH_ADDR;
            default: state_d = PH_IDLE;
        endcase
    end

    // low address capture, edge-sampled equivalent of a transparent latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lo_q <= '0;
        else if (ale_i) lo_q <= ad_i;
    end

    // outputs
    always_comb begin
        data_ph_o = 1'b0;
        unique case (state_q)
            PH_IDLE: data_ph_o = 1'b0;
            PH_ADDR: data_ph_o = 1'b0;
            PH_DATA: data_ph_o = !ale_i;
            default: data_ph_o = 1'b0;
        endcase
    end

    assign lo_q_o = lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ale_i)) |-> (lo_q_o == $past(ad_i))); // R2
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(ale_i)) |-> $stable(lo_q_o)); // R2
    AST_NO_DATA_DURING_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_i |-> !data_ph_o); // R4

endmodule

// File: rtl/bdm_cmd_decode.sv
module bdm_cmd_decode #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          ale_i,
    input  logic          io_m_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic [DW-1:0] ad_i,
    input  logic [DW-1:0] rdata_i,
    output logic          mem_rd_n_o,
    output logic          mem_wr_n_o,
    output logic          io_rd_n_o,
    output logic          io_wr_n_o,
    output logic          bus_err_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o
);
    logic conflict;
    logic rd_go;
    logic wr_go;

    assign conflict = !rd_n_i && !wr_n_i;
    assign rd_go    = active_i && !rd_n_i && wr_n_i;
    assign wr_go    = active_i && !wr_n_i && rd_n_i;

    always_comb begin
        mem_rd_n_o = !(rd_go && !io_m_i);
        mem_wr_n_o = !(wr_go && !io_m_i);
        io_rd_n_o  = !(rd_go &&  io_m_i);
        io_wr_n_o  = !(wr_go &&  io_m_i);
        bus_err_o  = active_i && conflict;
        ad_oe_o    = rd_go;
        ad_o       = rd_go ? rdata_i : '0;
        wdata_o    = wr_go ? ad_i : '0;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!mem_rd_n_o, !mem_wr_n_o, !io_rd_n_o, !io_wr_n_o})); // R3
    AST_QUIET_DURING_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_i |-> (mem_rd_n_o && mem_wr_n_o && io_rd_n_o && io_wr_n_o)); // R4
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (mem_rd_n_o && mem_wr_n_o && io_rd_n_o && io_wr_n_o)); // R5
    AST_OE_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> (!mem_rd_n_o || !io_rd_n_o)); // R10

endmodule

// File: rtl/bdm_chip_select.sv
module bdm_chip_select #(
    parameter int ADDR_W     = 16,
    parameter int DEV_AW     = 11,
    parameter int SEL_W      = 2,
    parameter bit EXHAUSTIVE = 1'b1,
    parameter int HI_MATCH   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [(1<<SEL_W)-1:0]   cs_n_o
);
    localparam int NDEV   = 1 << SEL_W;
    localparam int EN_BIT = DEV_AW + SEL_W;
    localparam int HI_LSB = EN_BIT + 1;
    localparam int HI_W   = ADDR_W - HI_LSB;

    logic             hit;
    logic [SEL_W-1:0] sel;

    assign sel = addr_i[EN_BIT-1:DEV_AW];

    generate
        if (EXHAUSTIVE) begin : g_full
            logic [HI_W-1:0] hi_ref;
            assign hi_ref = HI_MATCH[HI_W-1:0];
            assign hit = en_i && addr_i[EN_BIT] && (addr_i[ADDR_W-1:HI_LSB] == hi_ref);
        end else begin : g_part
            assign hit = en_i && addr_i[EN_BIT];
        end
    endgenerate

    generate
        for (genvar k = 0; k < NDEV; k++) begin : g_cs
            assign cs_n_o[k] = !(hit && (sel == SEL_W'(k)));
        end
    endgenerate

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R6
    AST_CS_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (&cs_n_o)); // R4

endmodule

// File: rtl/bdm_bus_demux.sv
module bdm_bus_demux #(
    parameter int LO_W       = 8,
    parameter int ADDR_W     = 16,
    parameter int DEV_AW     = 11,
    parameter int SEL_W      = 2,
    parameter bit EXHAUSTIVE = 1'b1,
    parameter int HI_MATCH   = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ale_i,
    input  logic [LO_W-1:0]            ad_i,
    input  logic [ADDR_W-LO_W-1:0]     a_hi_i,
    input  logic                       io_m_i,
    input  logic                       rd_n_i,
    input  logic                       wr_n_i,
    input  logic [LO_W-1:0]            rdata_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [DEV_AW-1:0]          dev_addr_o,
    output logic                       mem_rd_n_o,
    output logic                       mem_wr_n_o,
    output logic                       io_rd_n_o,
    output logic                       io_wr_n_o,
    output logic [(1<<SEL_W)-1:0]      cs_n_o,
    output logic                       bus_err_o,
    output logic [LO_W-1:0]            wdata_o,
    output logic [LO_W-1:0]            ad_o,
    output logic                       ad_oe_o
);
    logic [LO_W-1:0] lo_q;
    logic            data_ph;
    logic            mem_ph;

    bdm_phase_fsm #(.LO_W(LO_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_i     (ale_i),
        .ad_i      (ad_i),
        .lo_q_o    (lo_q),
        .data_ph_o (data_ph)
    );

    assign addr_o     = {a_hi_i, lo_q};
    assign dev_addr_o = addr_o[DEV_AW-1:0];
    assign mem_ph     = data_ph && !io_m_i;

    bdm_cmd_decode #(.DW(LO_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (data_ph),
        .ale_i      (ale_i),
        .io_m_i     (io_m_i),
        .rd_n_i     (rd_n_i),
        .wr_n_i     (wr_n_i),
        .ad_i       (ad_i),
        .rdata_i    (rdata_i),
        .mem_rd_n_o (mem_rd_n_o),
        .mem_wr_n_o (mem_wr_n_o),
        .io_rd_n_o  (io_rd_n_o),
        .io_wr_n_o  (io_wr_n_o),
        .bus_err_o  (bus_err_o),
        .wdata_o    (wdata_o),
        .ad_o       (ad_o),
        .ad_oe_o    (ad_oe_o)
    );

    bdm_chip_select #(
        .ADDR_W     (ADDR_W),
        .DEV_AW     (DEV_AW),
        .SEL_W      (SEL_W),
        .EXHAUSTIVE (EXHAUSTIVE),
        .HI_MATCH   (HI_MATCH)
    ) u_cs (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mem_ph),
        .addr_i (addr_o),
        .cs_n_o (cs_n_o)
    );

    AST_CS_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        io_m_i |-> (&cs_n_o)); // R6

endmodule

// File: tb/bdm_bus_demux_test.sv
module bdm_bus_demux_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0;
    logic [7:0] ad = 8'h00;
    logic [7:0] a_hi = 8'h00;
    logic       io_m = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] rdata = 8'h00;

    logic [15:0] addr_e, addr_p;
    logic [10:0] dev_e, dev_p;
    logic        mrd_e, mwr_e, ird_e, iwr_e;
    logic        mrd_p, mwr_p, ird_p, iwr_p;
    logic [3:0]  cs_e, cs_p;
    logic        err_e, err_p;
    logic [7:0]  wd_e, wd_p, ado_e, ado_p;
    logic        oe_e, oe_p;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bdm_bus_demux #(.EXHAUSTIVE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .ale_i(ale), .ad_i(ad), .a_hi_i(a_hi),
        .io_m_i(io_m), .rd_n_i(rd_n), .wr_n_i(wr_n), .rdata_i(rdata),
        .addr_o(addr_e), .dev_addr_o(dev_e),
        .mem_rd_n_o(mrd_e), .mem_wr_n_o(mwr_e), .io_rd_n_o(ird_e), .io_wr_n_o(iwr_e),
        .cs_n_o(cs_e), .bus_err_o(err_e), .wdata_o(wd_e), .ad_o(ado_e), .ad_oe_o(oe_e)
    );

    bdm_bus_demux #(.EXHAUSTIVE(1'b0)) uut_p (
        .clk(clk), .rst_n(rst_n), .ale_i(ale), .ad_i(ad), .a_hi_i(a_hi),
        .io_m_i(io_m), .rd_n_i(rd_n), .wr_n_i(wr_n), .rdata_i(rdata),
        .addr_o(addr_p), .dev_addr_o(dev_p),
        .mem_rd_n_o(mrd_p), .mem_wr_n_o(mwr_p), .io_rd_n_o(ird_p), .io_wr_n_o(iwr_p),
        .cs_n_o(cs_p), .bus_err_o(err_p), .wdata_o(wd_p), .ad_o(ado_p), .ad_oe_o(oe_p)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic mem, input logic [15:0] a, input logic full);
        logic hit;
        hit = mem && a[13] && (!full || a[15:14] == 2'b00);
        return hit ? ~(4'b0001 << a[12:11]) : 4'hF;
    endfunction

    task automatic bus_cycle(input logic iom, input logic rdn, input logic wrn,
                             input logic [15:0] adr, input logic [7:0] dat);
        logic conflict;
        logic [3:0] strb;
        conflict = !rdn && !wrn;
        strb = {!(!conflict && !iom && !rdn), !(!conflict && !iom && !wrn),
                !(!conflict &&  iom && !rdn), !(!conflict &&  iom && !wrn)};
        @(negedge clk);
        ale = 1'b1; ad = adr[7:0]; a_hi = adr[15:8]; io_m = iom; rd_n = 1'b1; wr_n = 1'b1;
        rdata = ~dat;
        @(negedge clk);
        ale = 1'b0; ad = dat; rd_n = rdn; wr_n = wrn;
        #1;
        // R4: still in address phase, nothing may assert yet
        chk("R4 strobes before data edge", {28'h0, mrd_e, mwr_e, ird_e, iwr_e}, 32'hF);
        chk("R4 cs before data edge", {28'h0, cs_p}, 32'hF);
        @(posedge clk); #1;
        chk("R2 addr held", {16'h0, addr_e}, {16'h0, adr});
        chk("R9 dev addr", {21'h0, dev_e}, {21'h0, adr[10:0]});
        chk("R3 strobes", {28'h0, mrd_e, mwr_e, ird_e, iwr_e}, {28'h0, strb});
        chk("R5 error flag", {31'h0, err_e}, {31'h0, conflict});
        chk("R7 exhaustive cs", {28'h0, cs_e}, {28'h0, exp_cs(!iom, adr, 1'b1)});
        chk("R8 partial cs", {28'h0, cs_p}, {28'h0, exp_cs(!iom, adr, 1'b0)});
        chk("R10 read return", {23'h0, oe_e, ado_e}, (!strb[3] || !strb[1]) ? {23'h0, 1'b1, ~dat} : 32'h0);
        chk("R10 write data", {24'h0, wd_e}, (!strb[2] || !strb[0]) ? {24'h0, dat} : 32'h0);
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 low byte after reset", {16'h0, addr_e}, 32'h0);
        chk("R1 strobes after reset", {28'h0, mrd_e, mwr_e, ird_e, iwr_e}, 32'hF);
        chk("R1 cs after reset", {28'h0, cs_e}, 32'hF);
        chk("R1 err and oe after reset", {30'h0, err_e, oe_e}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle state, read low without any latch enable asserts nothing
        @(negedge clk); rd_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 idle ignores read", {28'h0, mrd_e, mwr_e, ird_e, iwr_e}, 32'hF);
        @(negedge clk); rd_n = 1'b1;

        // main sweep: every high byte under each command (R3, R6, R7, R8)
        for (int h = 0; h < 256; h++) begin
            for (int c = 0; c < 4; c++) begin
                bus_cycle(c[1], c[0], !c[0], {h[7:0], h[7:0] ^ 8'h5A}, h[7:0] + 8'd3);
            end
        end

        // R5: conflicting requests in both spaces
        bus_cycle(1'b0, 1'b0, 1'b0, 16'h2345, 8'h11);
        bus_cycle(1'b1, 1'b0, 1'b0, 16'h0040, 8'h22);

        // R2: low byte held while data changes in data phase
        bus_cycle(1'b0, 1'b0, 1'b1, 16'h3ABC, 8'h77);
        @(negedge clk); ad = 8'hE1;
        @(posedge clk); #1;
        chk("R2 hold through data cycles", {16'h0, addr_e}, 32'h3ABC);

        // R4: latch enable raised inside data phase suppresses strobes and cs
        @(negedge clk); rd_n = 1'b0; io_m = 1'b0;
        @(posedge clk); #1;
        chk("R4 read asserted before ale", {31'h0, mrd_e}, 32'h0);
        @(negedge clk); ale = 1'b1; #1;
        chk("R4 strobes quiet with ale", {28'h0, mrd_e, mwr_e, ird_e, iwr_e}, 32'hF);
        chk("R4 cs quiet with ale", {28'h0, cs_p}, 32'hF);
        @(negedge clk); ale = 1'b0; rd_n = 1'b1;

        // R8: aliases of one location hit the same device in partial mode only
        for (int top = 0; top < 4; top++) begin
            bus_cycle(1'b0, 1'b0, 1'b1, {top[1:0], 1'b1, 2'b10, 11'h155}, 8'h0F);
            chk("R8 alias partial", {28'h0, cs_p}, 32'hB);
            chk("R7 alias exhaustive", {28'h0, cs_e}, (top == 0) ? 32'hB : 32'hF);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule